// File: doc/BRIEF.md
# Host Byte Load Port with Ready/Busy Status

This block lets a microprocessor-style host push configuration bytes into a chip over an 8-bit parallel bus with no shared clock. The host selects the port using two select lines of opposite polarity. It writes a byte by pulling an active-low write strobe, and it polls readiness by pulling an active-low read strobe. The four control lines pass through two-flop synchronisers into the internal clock domain. A write is recognised on each falling edge of the synchronised write strobe.

An accepted byte is loaded into a shift register. From there a downstream consumer drains it one bit per clock, most-significant bit first, under a valid/ready handshake. The port reports busy from the load until the eighth bit has been taken. A write that arrives while the port is busy is dropped and raises a sticky overrun flag.

A status read turns the data bus around. The port drives the top bit with ready (1) or busy (0), and drives every lower bit high. The output enable for the external tri-state buffer is active only during a selected read in which the write strobe is not also low. When both strobes are low together, the write is taken.

Top module: `abl_top`

## Requirements
- R1: The port is selected only while `sel_lo_n` is 0 and `sel_hi` is 1 together. Strobes with any other select combination load nothing and drive nothing.
- R2: A falling edge of the write strobe while selected loads `bus_i` once. Holding the strobe low loads no further byte.
- R3: During a selected status read, `bus_o[7]` is 1 when the port is ready and 0 when it is busy, and `bus_o[6:0]` are all 1.
- R4: When both strobes are low while selected, the write is taken and `bus_oe` stays 0.
- R5: `bus_oe` is 1 only while the port is selected with the read strobe low and the write strobe high. It returns to 0 once the read strobe rises.
- R6: `busy` rises the cycle after a byte is loaded and falls right after the eighth bit handshake.
- R7: A write while `busy` is 1 is discarded, and it sets `overrun`, which stays 1 until reset.
- R8: Bits leave on `bit_data` most-significant bit first. Each bit advances only on a cycle with `bit_valid` and `bit_ready` both high. While `bit_ready` is low, `bit_valid` and `bit_data` hold.
- R9: After reset, `busy`, `bit_valid`, `bus_oe` and `overrun` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_lo_n | input | 1 | Select line, active low |
| sel_hi | input | 1 | Select line, active high |
| wr_n | input | 1 | Write strobe, active low, asynchronous |
| rd_n | input | 1 | Read strobe, active low, asynchronous |
| bus_i | input | 8 | Data bus input from the pads |
| bus_o | output | 8 | Data bus value driven during status reads |
| bus_oe | output | 1 | Output enable for the external tri-state buffer |
| busy | output | 1 | Byte held and not fully shifted out |
| overrun | output | 1 | Sticky flag: a write arrived while busy |
| bit_valid | output | 1 | A bit is offered to the consumer |
| bit_data | output | 1 | The offered bit |
| bit_ready | input | 1 | Consumer accepts the offered bit |

## Verification
The embedded assertions check the following every cycle:
- the output enable only ever coincides with a selected, read-only strobe state;
- the status bit always mirrors the shifter's occupancy;
- a stalled bit holds, and a load puts the byte's top bit on the output next;
- overrun rises only after a write collides with busy, and never falls.

Other behaviours depend on whole host transactions, so only the bench scenarios can show them:
- a long-held write strobe loads only one byte;
- a dropped write leaves the first byte intact;
- both strobes low together yields a load with no bus drive;
- a deselected strobe has no effect;
- the bit order of random bytes under random stalls.

// File: rtl/abl_pkg.sv
// Shared definitions for the host byte load port.
// Assumes: one internal clock domain, host strobes asynchronous to it.
package abl_pkg;
    // Decoded, synchronised host request for one cycle.
    typedef struct packed {
        logic sel;     // both select lines in their active state
        logic wr_evt;  // selected falling edge of the write strobe
        logic rd_act;  // selected read with the write strobe inactive
    } abl_req_t;

    // Idle levels of {sel_lo_n, sel_hi, wr_n, rd_n}.
    localparam logic [3:0] ABL_CTRL_IDLE = 4'b1011;
endpackage

// File: rtl/abl_sync.sv
// Multi-stage synchroniser for a bundle of asynchronous control lines.
// Assumes: each line is a level that the host holds for several clocks;
// no bus coherence between lines is required.
module abl_sync #(
    parameter int              WIDTH  = 4,
    parameter int              STAGES = 2,
    parameter logic [WIDTH-1:0] IDLE  = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    // Shift each line through the stage chain, reset to the idle level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= IDLE;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/abl_strobe_decode.sv
// Turns synchronised select and strobe levels into per-cycle requests.
// Assumes: inputs already synchronised. Write has priority over read.
module abl_strobe_decode
    import abl_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     sel_lo_n_s,
    input  logic     sel_hi_s,
    input  logic     wr_n_s,
    input  logic     rd_n_s,
    output abl_req_t req
);
    logic wr_n_prev;

    // Remember last write strobe level for falling-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) wr_n_prev <= 1'b1;
        else        wr_n_prev <= wr_n_s;
    end

    // Form select, write event and read activity for this cycle.
    always_comb begin
        req.sel    = !sel_lo_n_s && sel_hi_s;
        req.wr_evt = req.sel && wr_n_prev && !wr_n_s;
        req.rd_act = req.sel && !rd_n_s && wr_n_s;
    end

    // A write event needs the strobe low in the previous decode cycle to be high.
    assert_single_event_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req.wr_evt |=> !req.wr_evt);
endmodule

// File: rtl/abl_bit_shifter.sv
// Byte buffer that unloads MSB first under a per-bit valid/ready handshake.
// Assumes: wr_evt is a one-cycle pulse and din is stable in that cycle.
module abl_bit_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_evt,
    input  logic [DATA_W-1:0] din,
    input  logic              bit_ready,
    output logic              bit_valid,
    output logic              bit_data,
    output logic              busy,
    output logic              overrun
);
    localparam int CNT_W = $clog2(DATA_W + 1);

    logic [DATA_W-1:0] shreg;
    logic [CNT_W-1:0]  left;

    assign busy      = (left != '0);
    assign bit_valid = busy;
    assign bit_data  = shreg[DATA_W-1];

    // Load a byte when free, otherwise shift one bit per accepted handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
            left  <= '0;
        end else if (wr_evt && !busy) begin
            shreg <= din;
            left  <= CNT_W'(DATA_W);
        end else if (busy && bit_ready) begin
            shreg <= {shreg[DATA_W-2:0], 1'b0};
            left  <= left - 1'b1;
        end
    end

    // Record any write that collided with a byte in flight.
    always_ff @(posedge clk) begin
        if (!rst_n)               overrun <= 1'b0;
        else if (wr_evt && busy)  overrun <= 1'b1;
    end

    assert_load_msb_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_evt && !busy) |=> (busy && bit_data == $past(din[DATA_W-1])));
    assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_valid && !bit_ready) |=> (bit_valid && $stable(bit_data)));
    assert_busy_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(bit_ready));
    assert_overrun_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);
    assert_overrun_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> $past(wr_evt && busy));
endmodule

// File: rtl/abl_bus_driver.sv
// Produces the status word and the tri-state enable for the host bus.
// Assumes: rd_act already excludes cycles with the write strobe low.
module abl_bus_driver #(
    parameter int DATA_W = 8
) (
    input  logic              rd_act,
    input  logic              busy,
    output logic [DATA_W-1:0] bus_o,
    output logic              bus_oe
);
    // Ready on the top bit, lower bits forced high, quiet when not reading.
    always_comb begin
        bus_oe = rd_act;
        bus_o  = rd_act ? {!busy, {(DATA_W-1){1'b1}}} : '0;
    end
endmodule

// File: rtl/abl_top.sv
// Host byte load port: synchronises host strobes, loads bytes, reports
// ready/busy on status reads and streams bytes bit-serially downstream.
// Assumes: host holds data stable while the write strobe is low.
module abl_top
    import abl_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_lo_n,
    input  logic              sel_hi,
    input  logic              wr_n,
    input  logic              rd_n,
    input  logic [DATA_W-1:0] bus_i,
    output logic [DATA_W-1:0] bus_o,
    output logic              bus_oe,
    output logic              busy,
    output logic              overrun,
    output logic              bit_valid,
    output logic              bit_data,
    input  logic              bit_ready
);
    logic [3:0] ctrl_s;
    abl_req_t   req;

    abl_sync #(.WIDTH(4), .STAGES(SYNC_STAGES), .IDLE(ABL_CTRL_IDLE)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sel_lo_n, sel_hi, wr_n, rd_n}),
        .q     (ctrl_s)
    );

    abl_strobe_decode u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_lo_n_s (ctrl_s[3]),
        .sel_hi_s   (ctrl_s[2]),
        .wr_n_s     (ctrl_s[1]),
        .rd_n_s     (ctrl_s[0]),
        .req        (req)
    );

    abl_bit_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_evt    (req.wr_evt),
        .din       (bus_i),
        .bit_ready (bit_ready),
        .bit_valid (bit_valid),
        .bit_data  (bit_data),
        .busy      (busy),
        .overrun   (overrun)
    );

    abl_bus_driver #(.DATA_W(DATA_W)) u_bus (
        .rd_act (req.rd_act),
        .busy   (busy),
        .bus_o  (bus_o),
        .bus_oe (bus_oe)
    );

    assert_oe_select_R1: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> (!ctrl_s[3] && ctrl_s[2]));
    assert_oe_read_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> (!ctrl_s[0] && ctrl_s[1]));
    assert_write_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        req.wr_evt |-> !bus_oe);
    assert_status_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> (bus_o[DATA_W-1] != bit_valid && (&bus_o[DATA_W-2:0])));
endmodule

// File: tb/abl_top_bench.sv
module abl_top_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel_lo_n = 1'b1, sel_hi = 1'b0, wr_n = 1'b1, rd_n = 1'b1;
    logic [7:0] bus_i = 8'h00;
    logic [7:0] bus_o;
    logic       bus_oe, busy, overrun, bit_valid, bit_data;
    logic       bit_ready = 1'b0;
    int         checks = 0, failures = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    abl_top u_abl_top (
        .clk(clk), .rst_n(rst_n), .sel_lo_n(sel_lo_n), .sel_hi(sel_hi),
        .wr_n(wr_n), .rd_n(rd_n), .bus_i(bus_i), .bus_o(bus_o),
        .bus_oe(bus_oe), .busy(busy), .overrun(overrun),
        .bit_valid(bit_valid), .bit_data(bit_data), .bit_ready(bit_ready)
    );

    function automatic bit is_sel(logic lo_n, logic hi);
        return !lo_n && hi;
    endfunction

    function automatic logic [7:0] status_word(bit ready);
        return {ready, 7'h7F};
    endfunction

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic waitn(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_write(logic lo_n, logic hi, logic [7:0] d, int hold);
        @(negedge clk); sel_lo_n = lo_n; sel_hi = hi; bus_i = d;
        waitn(1); wr_n = 1'b0;
        waitn(hold); wr_n = 1'b1;
        waitn(4); sel_lo_n = 1'b1; sel_hi = 1'b0;
        waitn(4);
    endtask

    task automatic do_read(logic lo_n, logic hi, output logic oe, output logic [7:0] v,
                           output logic oe_after);
        @(negedge clk); sel_lo_n = lo_n; sel_hi = hi;
        waitn(1); rd_n = 1'b0;
        waitn(4); oe = bus_oe; v = bus_o;
        rd_n = 1'b1;
        waitn(4); oe_after = bus_oe;
        sel_lo_n = 1'b1; sel_hi = 1'b0;
        waitn(4);
    endtask

    // Collect bits with random stalls; returns the byte and the bit count.
    task automatic drain(output logic [7:0] b, output int nbits);
        b = 8'h00; nbits = 0;
        for (int c = 0; c < 400 && nbits < 8; c++) begin
            @(negedge clk);
            bit_ready = ($urandom % 3) != 0;
            if (bit_valid && bit_ready) begin
                b = {b[6:0], bit_data};
                nbits++;
            end
        end
        @(negedge clk); bit_ready = 1'b0;
    endtask

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk); cyc++;
            if (cyc > 150000) begin
                failures++; checks++;
                $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    initial begin
        logic       oe, oe2;
        logic [7:0] v, b;
        int         n;
        void'($urandom(32'd1234));
        waitn(4); rst_n = 1'b1; waitn(1);
        // R9 reset state
        check(!busy && !bit_valid && !bus_oe && !overrun, "R9",
              {busy, bit_valid, bus_oe, overrun}, 0);

        // R3 / R5 idle status read
        do_read(1'b0, 1'b1, oe, v, oe2);
        check(oe == 1'b1, "R5", oe, 1);
        check(v == status_word(1'b1), "R3", v, status_word(1'b1));
        check(oe2 == 1'b0, "R5", oe2, 0);

        // R1 wrong select: no drive, no load
        do_read(1'b1, 1'b1, oe, v, oe2);
        check(oe == 1'b0, "R1", oe, 0);
        do_write(1'b0, 1'b0, 8'hA5, 5);
        check(busy == 1'b0, "R1", busy, 0);
        do_write(1'b1, 1'b1, 8'hA5, 5);
        check(busy == 1'b0, "R1", busy, 0);

        // R2 long strobe loads once; R6 busy then R3 busy status
        do_write(1'b0, 1'b1, 8'hC3, 30);
        check(busy == 1'b1, "R6", busy, 1);
        do_read(1'b0, 1'b1, oe, v, oe2);
        check(v == status_word(1'b0), "R3", v, status_word(1'b0));
        // R7 write while busy discarded
        do_write(1'b0, 1'b1, 8'h3C, 5);
        check(overrun == 1'b1, "R7", overrun, 1);
        drain(b, n);
        check(b == 8'hC3, "R7", b, 8'hC3);
        check(n == 8, "R8", n, 8);
        check(busy == 1'b0 && bit_valid == 1'b0, "R2", busy, 0);
        check(overrun == 1'b1, "R7", overrun, 1);

        // R4 both strobes low: write taken, no drive
        @(negedge clk); sel_lo_n = 1'b0; sel_hi = 1'b1; bus_i = 8'h96;
        waitn(1); wr_n = 1'b0; rd_n = 1'b0;
        waitn(5);
        check(bus_oe == 1'b0, "R4", bus_oe, 0);
        check(busy == 1'b1, "R4", busy, 1);
        wr_n = 1'b1; rd_n = 1'b1; waitn(4);
        sel_lo_n = 1'b1; sel_hi = 1'b0; waitn(4);
        drain(b, n);
        check(b == 8'h96, "R4", b, 8'h96);

        // R8 stall holds data
        do_write(1'b0, 1'b1, 8'h80, 5);
        v[0] = bit_data; waitn(6);
        check(bit_valid && bit_data == v[0] && v[0] == 1'b1, "R8", bit_data, 1);
        drain(b, n);
        check(b == 8'h80, "R8", b, 8'h80);

        // Random selects and bytes
        for (int k = 0; k < 40; k++) begin
            logic       lo_n, hi;
            logic [7:0] d;
            lo_n = ($urandom % 4) == 0;
            hi   = ($urandom % 4) != 0;
            d    = 8'($urandom);
            do_write(lo_n, hi, d, 3 + ($urandom % 6));
            check(busy == is_sel(lo_n, hi), "R1", busy, is_sel(lo_n, hi));
            if (is_sel(lo_n, hi)) begin
                drain(b, n);
                check(b == d && n == 8, "R8", b, d);
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule